// File: doc/BRIEF.md
# Variable-Length Instruction Word Decoder

This block decodes the leading 16-bit word of an instruction for a small 16-bit processor. In the same cycle that the fetch stage presents the word with its valid strobe, it returns the 6-bit opcode, the instruction format, the register indices and a normalised addressing-mode code. It also returns the number of words the whole instruction occupies, so the fetch stage knows how many extension words to collect before it hands the instruction on.

The addressing-mode field that follows the opcode has a variable width. When its leading bit is 0 it is two bits wide and two 4-bit register fields follow it. When its leading bit is 1 it is four bits wide and a single register or flag index sits in the lowest nibble. The four opcodes that compare two registers and branch read a separate 2-bit mode table instead. Jump opcodes accept only a subset of the modes. Return opcodes and the all-ones no-operation word carry no mode. The block does not fetch the extension words, form the address or execute anything. It is purely combinational.

Top module: `instr_word_decoder`

## Requirements
- R1: While `word_valid` is high, `opcode` equals `word_in[15:10]` for every input word.
- R2: For a general opcode whose `word_in[9]` is 0, `word_in[8]`=0 gives `amode` 1 (register) and `word_in[8]`=1 gives `amode` 2 (register indirect). `fmt` is 2 (two registers), `src_reg` is `word_in[7:4]` and `dst_reg` is `word_in[3:0]`.
- R3: For a general opcode whose `word_in[9]` is 1, the code `word_in[9:6]` maps 1000→`amode` 3 (immediate), 1001→4 (direct sector), 1010→5 (direct absolute), 1011→6 (indirect via Z) and 1100→7 (Z plus offset). `fmt` is 1 (one register), `dst_reg` is `word_in[3:0]` and `src_reg` is 0.
- R4: `word_count` is 1 for `amode` 0, 1, 2 and 6. It is 2 for `amode` 3, 4 and 7, and 3 for `amode` 5.
- R5: The opcodes 100110, 100111, 101000 and 101001 decode `word_in[9:8]` as 00→`amode` 4, 01→5, 10→6 and 11→7. They give `fmt` 3 (compare branch), `src_reg` = `word_in[7:4]`, `dst_reg` = `word_in[3:0]`, and are never illegal.
- R6: A general opcode with the 4-bit code 1101, 1110 or 1111 raises `illegal`, with `amode` 0, `word_count` 1, `fmt` 1 and `dst_reg` = `word_in[3:0]`.
- R7: The opcodes 110000 and 110001 give `fmt` 0 with both register outputs 0. Only the codes 1001, 1010, 1011 and 1100 are accepted; any other mode field, including a 2-bit one, raises `illegal` with `amode` 0.
- R8: The word 0xFFFF decodes as a legal no-operation: `opcode` 0x3F, `fmt` 0, `amode` 0, `word_count` 1. Any other word with opcode 111111 raises `illegal`.
- R9: The opcodes 110010 and 110011 give `fmt` 0, `amode` 0, register outputs 0, `word_count` 1 and no `illegal`, whatever `word_in[9:0]` holds.
- R10: While `word_valid` is low, `dec_valid`, `opcode`, `amode`, `fmt`, `src_reg`, `dst_reg`, `word_count` and `illegal` are all 0. While it is high, `dec_valid` is 1 and the decode appears without a clock cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_valid | input | 1 | Strobe qualifying `word_in` |
| word_in | input | 16 | First word of the instruction |
| dec_valid | output | 1 | Decode outputs are meaningful |
| opcode | output | 6 | Opcode field |
| amode | output | 3 | Normalised addressing mode: 0 none, 1 register, 2 register indirect, 3 immediate, 4 direct sector, 5 direct absolute, 6 indirect Z, 7 Z plus offset |
| fmt | output | 2 | Format: 0 no register, 1 one register, 2 two registers, 3 compare branch |
| src_reg | output | 4 | Source register index |
| dst_reg | output | 4 | Destination register, register-or-flag index, or second compare register |
| word_count | output | 2 | Total instruction length in words (1 to 3) |
| illegal | output | 1 | Encoding not permitted |

## Verification
The bench places the same bit patterns in the mode field under general, compare-branch and jump opcodes. A decoder that ignored the opcode class would report the wrong mode for a compare branch, or accept an immediate jump. The reserved codes 1101 to 1111 and a 2-bit mode on a jump are applied to show that `illegal` rises and the word count drops back to 1 instead of reporting extension words. The no-operation word is checked against a near miss that shares its opcode. A return opcode is given junk in its low bits, which a decoder would wrongly pass through as registers or a mode. The valid strobe is dropped on both legal and illegal words to show that every output clears.

// File: rtl/iwd_pkg.sv
package iwd_pkg;

    localparam int WORD_W  = 16;
    localparam int OP_W    = 6;
    localparam int REG_W   = 4;
    localparam int MODE_W  = 4;
    localparam int CNT_W   = 2;
    localparam int OP_LSB  = WORD_W - OP_W;      // opcode occupies the top bits
    localparam int MODE_HI = OP_LSB - 1;         // first bit of the mode field
    localparam int MODE_LO = MODE_HI - MODE_W + 1;
    localparam int BRM_LO  = MODE_HI - 1;        // 2-bit compare-branch table

    typedef logic [OP_W-1:0]  opcode_t;
    typedef logic [REG_W-1:0] reg_idx_t;
    typedef logic [CNT_W-1:0] count_t;

    typedef enum logic [2:0] {
        AM_NONE, AM_REG, AM_IND_REG, AM_IMM,
        AM_DIR_SEC, AM_DIR_ABS, AM_IND_Z, AM_IDX_Z
    } amode_e;

    typedef enum logic [1:0] {
        FMT_NO_REG, FMT_ONE_REG, FMT_TWO_REG, FMT_CMP_BR
    } fmt_e;

    typedef enum logic [2:0] {
        CL_GENERAL, CL_CMP_BR, CL_JUMP, CL_RETURN, CL_NOP
    } opclass_e;

    localparam opcode_t OP_BEQ  = 6'b100110;
    localparam opcode_t OP_BNE  = 6'b100111;
    localparam opcode_t OP_BGT  = 6'b101000;
    localparam opcode_t OP_BGE  = 6'b101001;
    localparam opcode_t OP_JMP  = 6'b110000;
    localparam opcode_t OP_CALL = 6'b110001;
    localparam opcode_t OP_RET  = 6'b110010;
    localparam opcode_t OP_RETI = 6'b110011;
    localparam opcode_t OP_NOP  = 6'b111111;

    localparam int N_CMP = 4;
    localparam logic [N_CMP*OP_W-1:0] CMP_OPS = {OP_BEQ, OP_BNE, OP_BGT, OP_BGE};

    typedef struct packed {
        opcode_t  opcode;
        amode_e   mode;
        fmt_e     fmt;
        reg_idx_t src;
        reg_idx_t dst;
        count_t   words;
        logic     illegal;
    } decode_t;

    // Total instruction length implied by a normalised mode
    function automatic count_t total_words(amode_e m);
        case (m)
            AM_IMM, AM_DIR_SEC, AM_IDX_Z: total_words = count_t'(2);
            AM_DIR_ABS:                   total_words = count_t'(3);
            default:                      total_words = count_t'(1);
        endcase
    endfunction

    function automatic logic jump_mode_ok(amode_e m);
        jump_mode_ok = (m == AM_DIR_SEC) || (m == AM_DIR_ABS) ||
                       (m == AM_IND_Z)   || (m == AM_IDX_Z);
    endfunction

endpackage

// File: rtl/iwd_opclass.sv
module iwd_opclass
    import iwd_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output opclass_e        cls
);
    logic [N_CMP-1:0] cmp_hit;

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        assign cmp_hit[i] = (op == CMP_OPS[i*OP_W +: OP_W]);
    end

    always_comb begin
        if (|cmp_hit)                            cls = CL_CMP_BR;
        else if (op == OP_JMP || op == OP_CALL)  cls = CL_JUMP;
        else if (op == OP_RET || op == OP_RETI)  cls = CL_RETURN;
        else if (op == OP_NOP)                   cls = CL_NOP;
        else                                     cls = CL_GENERAL;
    end
endmodule

// File: rtl/iwd_mode_gen.sv
module iwd_mode_gen
    import iwd_pkg::*;
(
    input  logic [MODE_W-1:0] fld,
    output amode_e            mode,
    output logic              wide,
    output logic              bad
);
    always_comb begin
        wide = fld[MODE_W-1];
        bad  = 1'b0;
        mode = AM_NONE;
        if (!wide) begin
            mode = fld[MODE_W-2] ? AM_IND_REG : AM_REG;
        end else begin
            case (fld[MODE_W-2:0])
                3'b000:  mode = AM_IMM;
                3'b001:  mode = AM_DIR_SEC;
                3'b010:  mode = AM_DIR_ABS;
                3'b011:  mode = AM_IND_Z;
                3'b100:  mode = AM_IDX_Z;
                default: bad  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/iwd_mode_br.sv
module iwd_mode_br
    import iwd_pkg::*;
(
    input  logic [1:0] fld,
    output amode_e     mode
);
    always_comb begin
        case (fld)
            2'b00:   mode = AM_DIR_SEC;
            2'b01:   mode = AM_DIR_ABS;
            2'b10:   mode = AM_IND_Z;
            default: mode = AM_IDX_Z;
        endcase
    end
endmodule

// File: rtl/instr_word_decoder.sv
module instr_word_decoder
    import iwd_pkg::*;
(
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              dec_valid,
    output logic [OP_W-1:0]   opcode,
    output logic [2:0]        amode,
    output logic [1:0]        fmt,
    output logic [REG_W-1:0]  src_reg,
    output logic [REG_W-1:0]  dst_reg,
    output logic [CNT_W-1:0]  word_count,
    output logic              illegal
);
    opclass_e cls;
    amode_e   gen_mode, br_mode;
    logic     gen_wide, gen_bad;
    decode_t  d, q;

    iwd_opclass u_cls (
        .op  (word_in[WORD_W-1:OP_LSB]),
        .cls (cls)
    );

    iwd_mode_gen u_gen (
        .fld  (word_in[MODE_HI:MODE_LO]),
        .mode (gen_mode),
        .wide (gen_wide),
        .bad  (gen_bad)
    );

    iwd_mode_br u_br (
        .fld  (word_in[MODE_HI:BRM_LO]),
        .mode (br_mode)
    );

    always_comb begin
        d         = '0;
        d.opcode  = word_in[WORD_W-1:OP_LSB];
        d.mode    = AM_NONE;
        d.fmt     = FMT_NO_REG;
        case (cls)
            CL_CMP_BR: begin
                d.fmt  = FMT_CMP_BR;
                d.mode = br_mode;
                d.src  = word_in[2*REG_W-1:REG_W];
                d.dst  = word_in[REG_W-1:0];
            end
            CL_JUMP: begin
                if (gen_wide && !gen_bad && jump_mode_ok(gen_mode))
                    d.mode = gen_mode;
                else
                    d.illegal = 1'b1;
            end
            CL_RETURN: ;
            CL_NOP: d.illegal = (word_in != '1);
            default: begin
                d.dst = word_in[REG_W-1:0];
                if (gen_bad) begin
                    d.fmt     = FMT_ONE_REG;
                    d.illegal = 1'b1;
                end else if (gen_wide) begin
                    d.fmt  = FMT_ONE_REG;
                    d.mode = gen_mode;
                end else begin
                    d.fmt  = FMT_TWO_REG;
                    d.mode = gen_mode;
                    d.src  = word_in[2*REG_W-1:REG_W];
                end
            end
        endcase
        d.words = total_words(d.mode);
        q = word_valid ? d : '0;
    end

    assign dec_valid  = word_valid;
    assign opcode     = q.opcode;
    assign amode      = q.mode;
    assign fmt        = q.fmt;
    assign src_reg    = q.src;
    assign dst_reg    = q.dst;
    assign word_count = q.words;
    assign illegal    = q.illegal;
endmodule

// File: rtl/iwd_chk.sv
module iwd_chk
    import iwd_pkg::*;
(
    input logic              word_valid,
    input logic [WORD_W-1:0] word_in,
    input logic              dec_valid,
    input logic [OP_W-1:0]   opcode,
    input logic [2:0]        amode,
    input logic [1:0]        fmt,
    input logic [REG_W-1:0]  src_reg,
    input logic [REG_W-1:0]  dst_reg,
    input logic [CNT_W-1:0]  word_count,
    input logic              illegal
);
    always_comb begin
        if (word_valid) begin
            a_r1_opcode_field: assert (opcode == word_in[WORD_W-1:OP_LSB])
                else $error("opcode field mismatch");
            a_r4_count_range: assert (word_count >= 2'd1)
                else $error("word count out of range");
        end
        if (illegal) begin
            a_r6_illegal_single: assert (word_count == 2'd1 && amode == 3'd0)
                else $error("illegal word reports extension words");
        end
        if (word_valid && fmt == 2'd3) begin
            a_r5_cmpbr_mode: assert (amode >= 3'd4 && !illegal)
                else $error("compare branch with bad mode");
        end
        if (word_valid && fmt == 2'd0) begin
            a_r7_noreg_zero: assert (src_reg == '0 && dst_reg == '0)
                else $error("register output on no-register format");
        end
        if (!word_valid) begin
            a_r10_idle: assert (!dec_valid && opcode == '0 && amode == '0 &&
                                fmt == '0 && src_reg == '0 && dst_reg == '0 &&
                                word_count == '0 && !illegal)
                else $error("outputs active without strobe");
        end
    end
endmodule

bind instr_word_decoder iwd_chk i_chk (.*);

// File: tb/test_instr_word_decoder.sv
module test_instr_word_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 23;

    logic        clk = 1'b0;
    logic        word_valid;
    logic [15:0] word_in;
    logic        dec_valid;
    logic [5:0]  opcode;
    logic [2:0]  amode;
    logic [1:0]  fmt;
    logic [3:0]  src_reg, dst_reg;
    logic [1:0]  word_count;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    instr_word_decoder i_instr_word_decoder (
        .word_valid (word_valid), .word_in (word_in), .dec_valid (dec_valid),
        .opcode (opcode), .amode (amode), .fmt (fmt), .src_reg (src_reg),
        .dst_reg (dst_reg), .word_count (word_count), .illegal (illegal)
    );

    // {word, opcode, amode, fmt, src, dst, count, illegal}
    localparam logic [37:0] VEC [NV] = '{
        {16'h4435, 6'h11, 3'd1, 2'd2, 4'h3, 4'h5, 2'd1, 1'b0}, // R2 register
        {16'h09A1, 6'h02, 3'd2, 2'd2, 4'hA, 4'h1, 2'd1, 1'b0}, // R2 indirect
        {16'h0A07, 6'h02, 3'd3, 2'd1, 4'h0, 4'h7, 2'd2, 1'b0}, // R3 immediate
        {16'h0A42, 6'h02, 3'd4, 2'd1, 4'h0, 4'h2, 2'd2, 1'b0}, // R3 sector
        {16'h128F, 6'h04, 3'd5, 2'd1, 4'h0, 4'hF, 2'd3, 1'b0}, // R3/R4 absolute
        {16'h0AC0, 6'h02, 3'd6, 2'd1, 4'h0, 4'h0, 2'd1, 1'b0}, // R3 indirect Z
        {16'h4703, 6'h11, 3'd7, 2'd1, 4'h0, 4'h3, 2'd2, 1'b0}, // R3 indexed
        {16'h4F41, 6'h13, 3'd0, 2'd1, 4'h0, 4'h1, 2'd1, 1'b1}, // R6 code 1101
        {16'h0BC0, 6'h02, 3'd0, 2'd1, 4'h0, 4'h0, 2'd1, 1'b1}, // R6 code 1111
        {16'h9812, 6'h26, 3'd4, 2'd3, 4'h1, 4'h2, 2'd2, 1'b0}, // R5 00
        {16'hA134, 6'h28, 3'd5, 2'd3, 4'h3, 4'h4, 2'd3, 1'b0}, // R5 01
        {16'h9E56, 6'h27, 3'd6, 2'd3, 4'h5, 4'h6, 2'd1, 1'b0}, // R5 10
        {16'hA778, 6'h29, 3'd7, 2'd3, 4'h7, 4'h8, 2'd2, 1'b0}, // R5 11
        {16'hC240, 6'h30, 3'd4, 2'd0, 4'h0, 4'h0, 2'd2, 1'b0}, // R7 sector
        {16'hC680, 6'h31, 3'd5, 2'd0, 4'h0, 4'h0, 2'd3, 1'b0}, // R7 absolute
        {16'hC2C0, 6'h30, 3'd6, 2'd0, 4'h0, 4'h0, 2'd1, 1'b0}, // R7 indirect Z
        {16'hC300, 6'h30, 3'd7, 2'd0, 4'h0, 4'h0, 2'd2, 1'b0}, // R7 indexed
        {16'hC200, 6'h30, 3'd0, 2'd0, 4'h0, 4'h0, 2'd1, 1'b1}, // R7 immediate forbidden
        {16'hC000, 6'h30, 3'd0, 2'd0, 4'h0, 4'h0, 2'd1, 1'b1}, // R7 short mode forbidden
        {16'hFFFF, 6'h3F, 3'd0, 2'd0, 4'h0, 4'h0, 2'd1, 1'b0}, // R8 nop
        {16'hFC00, 6'h3F, 3'd0, 2'd0, 4'h0, 4'h0, 2'd1, 1'b1}, // R8 near miss
        {16'hCBA5, 6'h32, 3'd0, 2'd0, 4'h0, 4'h0, 2'd1, 1'b0}, // R9 return, junk
        {16'hCC00, 6'h33, 3'd0, 2'd0, 4'h0, 4'h0, 2'd1, 1'b0}  // R9 return from interrupt
    };

    function automatic string tag_of(int i);
        if (i < 2)       return "R2";
        else if (i < 7)  return "R3/R4";
        else if (i < 9)  return "R6";
        else if (i < 13) return "R5";
        else if (i < 19) return "R7";
        else if (i < 21) return "R8";
        else             return "R9";
    endfunction

    task automatic check(input string req, input logic [21:0] act, input logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [21:0] outs();
        return {opcode, amode, fmt, src_reg, dst_reg, word_count, illegal};
    endfunction

    task automatic apply(input logic v, input logic [15:0] w);
        @(negedge clk);
        word_valid = v;
        word_in    = w;
        #1;
    endtask

    initial begin
        word_valid = 1'b0;
        word_in    = 16'h0000;
        #1;
        // R10: idle state before any strobe
        check("R10 idle", {outs()}, 22'h0);
        check("R10 dec_valid low", {21'h0, dec_valid}, 22'h0);

        for (int i = 0; i < NV; i++) begin
            apply(1'b1, VEC[i][37:22]);
            check(tag_of(i), outs(), VEC[i][21:0]);
            // R1: opcode field always tracks the word
            check("R1 opcode", {16'h0, opcode}, {16'h0, VEC[i][37:32]});
        end

        // R10: strobe dropped on a legal and an illegal word
        apply(1'b0, 16'h4435);
        check("R10 legal word no strobe", outs(), 22'h0);
        check("R10 dec_valid", {21'h0, dec_valid}, 22'h0);
        apply(1'b0, 16'h4F41);
        check("R10 illegal word no strobe", outs(), 22'h0);
        apply(1'b1, 16'h128F);
        check("R10 same-cycle decode", {21'h0, dec_valid}, 22'h1);
        check("R4 three words", {20'h0, word_count}, 22'd3);
        // R6: remaining reserved code 1110
        apply(1'b1, 16'h0B83);
        check("R6 code 1110", outs(), {6'h02, 3'd0, 2'd1, 4'h0, 4'h3, 2'd1, 1'b1});

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule